// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo serial audio stream, made of a bit clock, a word-select (frame sync) line and a data line, and turns each channel half of a frame into one 32-bit word for a downstream receive FIFO. The serial inputs are already synchronized to the system clock. The block finds rising bit-clock edges by sampling the bit clock with the system clock, and it takes one data bit per rising edge.

Three framings are handled by one slot counter. In I2S framing, data starts one bit after each word-select transition. In left-justified framing, data starts on the transition bit itself. In right-justified framing, the sample is packed against the end of its half. A static format code and a static length code select the framing and the sample length. Every frame holds 64 bit slots, 32 per channel. Each word leaves the block sign-extended to 32 bits, with a channel flag, over a valid/ready handshake. A sticky overflow flag records each word that was lost because the previous word had not yet been taken.

Top module: `audio_ser_rx`

## Requirements
- R1: After reset, word_valid and overflow are 0. No word is emitted until the block has seen a word-select transition and then a full half of 32 slots.
- R2: The slot count restarts at slot 0 on each effective word-select transition, and each full half yields exactly one word. A half cut short by a new transition before slot 31 is dropped. Slots after slot 31 are ignored until the next transition.
- R3: When fmt_sel=0 (I2S), slot 0 is the bit that follows the bit in which frame_sync changed. The half with frame_sync low is the left channel.
- R4: When fmt_sel=1 (left-justified), slot 0 is the bit in which frame_sync changed. The half with frame_sync high is left. The sample MSB is in slot 0, and slots past the sample length are ignored.
- R5: When fmt_sel=2 (right-justified), the sample LSB is in slot 31 and the MSB is in slot 32-L. The leading slots are ignored. Framing and channel polarity are the same as for fmt_sel=1.
- R6: len_sel selects the sample length L: 0=16, 1=18, 2=20, 3=24, 4=32 bits. A sample shorter than 32 bits is sign-extended from its bit L-1 into word_data.
- R7: word_right is 0 for the left half and 1 for the right half. While word_valid is 1 and word_ready is 0, word_data and word_right hold steady. A word is taken on a clock edge where word_valid and word_ready are both 1.
- R8: A word that completes while the output holds an untaken word is dropped. The held word is kept, and overflow is set and stays 1 until reset. A word that completes in the same cycle as the held word is taken is loaded, and no overflow results.
- R9: Data and frame_sync are taken on rising bit_clk edges. bit_clk must stay high for at least one system clock and low for at least one system clock. At most one bit is taken per bit-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Serial bit clock, synchronized to clk |
| frame_sync | input | 1 | Word-select line, synchronized to clk |
| ser_data | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 treated as left-justified |
| len_sel | input | 3 | Sample length code (see R6); codes 5 to 7 mean 32 |
| word_valid | output | 1 | Output word available |
| word_data | output | 32 | Sign-extended sample |
| word_right | output | 1 | Channel flag, 1 = right |
| word_ready | input | 1 | Downstream FIFO can take a word |
| overflow | output | 1 | Sticky flag: a completed word was lost |

## Verification
A word can complete in the same cycle that the downstream side takes the word still held at the output. In that cycle, loading the new word and releasing the old one compete in one register. The bench provokes this by holding word_ready low through a whole frame and raising it exactly during the last bit of the right half. The scoreboard must then receive both the left and the right words, in order, and overflow must read 0. A companion run keeps word_ready low through both halves. There the scoreboard expects only the left word, and overflow must read 1.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_CODE_W = 3;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

    typedef struct packed {
        logic              right;
        logic [WORD_W-1:0] data;
    } word_t;

    typedef struct packed {
        logic stb;
        logic val;
        logic ws;
        logic ws_edge;
    } bit_ev_t;

    // sample length in bits for a length code
    function automatic logic [5:0] len_bits(logic [LEN_CODE_W-1:0] code);
        case (code)
            3'd0:    return 6'd16;
            3'd1:    return 6'd18;
            3'd2:    return 6'd20;
            3'd3:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    // word-select level that marks the left channel
    function automatic logic left_level(fmt_e fmt);
        return (fmt == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction

    // place the sample in the top bits, then arithmetic shift down
    function automatic logic [WORD_W-1:0] align_word(logic [WORD_W-1:0] raw, fmt_e fmt,
                                                     logic [LEN_CODE_W-1:0] code);
        logic [5:0]        sh;
        logic [WORD_W-1:0] t;
        sh = 6'd32 - len_bits(code);
        t  = (fmt == FMT_RJ) ? (raw << sh) : raw;
        return WORD_W'($signed(t) >>> sh);
    endfunction

endpackage

// File: rtl/arx_bit_sampler.sv
module arx_bit_sampler
    import audio_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_clk,
    input  logic    frame_sync,
    input  logic    ser_data,
    input  fmt_e    fmt,
    output bit_ev_t ev
);
    logic       clk_q;
    logic       fs_prev_bit;
    logic       ws_q;
    logic [1:0] seen;
    logic [1:0] need;
    logic       rise;
    logic       ws_now;

    assign rise   = bit_clk & ~clk_q;
    // I2S: word select takes effect one bit late
    assign ws_now = (fmt == FMT_I2S) ? fs_prev_bit : frame_sync;
    assign need   = (fmt == FMT_I2S) ? 2'd2 : 2'd1;

    always_comb begin
        ev.stb     = rise;
        ev.val     = ser_data;
        ev.ws      = ws_now;
        ev.ws_edge = rise && (ws_now != ws_q) && (seen >= need);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q       <= 1'b1;
            fs_prev_bit <= 1'b0;
            ws_q        <= 1'b0;
            seen        <= 2'd0;
        end else begin
            clk_q <= bit_clk;
            if (rise) begin
                fs_prev_bit <= frame_sync;
                ws_q        <= ws_now;
                if (seen != 2'd2) seen <= seen + 2'd1;
            end
        end
    end
endmodule

// File: rtl/arx_framer.sv
module arx_framer
    import audio_rx_pkg::*;
#(
    parameter int SLOTS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bit_ev_t           ev,
    input  fmt_e              fmt,
    output logic              done,
    output logic              done_right,
    output logic [WORD_W-1:0] raw,
    output logic              synced
);
    localparam int CNT_W = $clog2(SLOTS);

    logic [CNT_W-1:0]  cnt;
    logic              active;
    logic              chan_right;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shifted;

    assign shifted = {shreg[WORD_W-2:0], ev.val};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            active     <= 1'b0;
            chan_right <= 1'b0;
            shreg      <= '0;
            done       <= 1'b0;
            done_right <= 1'b0;
            raw        <= '0;
            synced     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ev.stb) begin
                shreg <= shifted;
                if (ev.ws_edge) begin
                    cnt        <= CNT_W'(1);
                    active     <= 1'b1;
                    chan_right <= (ev.ws != left_level(fmt));
                    synced     <= 1'b1;
                end else if (active) begin
                    if (cnt == CNT_W'(SLOTS - 1)) begin
                        done       <= 1'b1;
                        done_right <= chan_right;
                        raw        <= shifted;
                        active     <= 1'b0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/arx_aligner.sv
module arx_aligner
    import audio_rx_pkg::*;
(
    input  logic                  right,
    input  logic [WORD_W-1:0]     raw,
    input  fmt_e                  fmt,
    input  logic [LEN_CODE_W-1:0] len_code,
    output word_t                 word
);
    always_comb begin
        word.right = right;
        word.data  = align_word(raw, fmt, len_code);
    end
endmodule

// File: rtl/arx_out_stage.sv
module arx_out_stage
    import audio_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_stb,
    input  word_t in_word,
    input  logic  ready,
    output logic  valid,
    output word_t held,
    output logic  ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            held  <= '0;
            ovf   <= 1'b0;
        end else begin
            if (valid && ready) valid <= 1'b0;
            if (in_stb) begin
                if (!valid || ready) begin
                    held  <= in_word;
                    valid <= 1'b1;
                end else begin
                    ovf <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/audio_ser_rx.sv
module audio_ser_rx
    import audio_rx_pkg::*;
#(
    parameter int SLOTS = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_clk,
    input  logic                  frame_sync,
    input  logic                  ser_data,
    input  logic [1:0]            fmt_sel,
    input  logic [LEN_CODE_W-1:0] len_sel,
    output logic                  word_valid,
    output logic [WORD_W-1:0]     word_data,
    output logic                  word_right,
    input  logic                  word_ready,
    output logic                  overflow
);
    fmt_e              fmt;
    bit_ev_t           ev;
    logic              frm_done;
    logic              frm_right;
    logic              frm_synced;
    logic [WORD_W-1:0] frm_raw;
    word_t             aligned;
    word_t             held;

    assign fmt = fmt_e'(fmt_sel);

    arx_bit_sampler u_smp (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .frame_sync(frame_sync),
        .ser_data(ser_data), .fmt(fmt), .ev(ev)
    );

    arx_framer #(.SLOTS(SLOTS)) u_frm (
        .clk(clk), .rst(rst), .ev(ev), .fmt(fmt), .done(frm_done),
        .done_right(frm_right), .raw(frm_raw), .synced(frm_synced)
    );

    arx_aligner u_aln (
        .right(frm_right), .raw(frm_raw), .fmt(fmt), .len_code(len_sel), .word(aligned)
    );

    arx_out_stage u_out (
        .clk(clk), .rst(rst), .in_stb(frm_done), .in_word(aligned),
        .ready(word_ready), .valid(word_valid), .held(held), .ovf(overflow)
    );

    assign word_data  = held.data;
    assign word_right = held.right;
endmodule

// File: rtl/audio_ser_rx_chk.sv
module audio_ser_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic        word_valid,
    input logic        word_ready,
    input logic        word_right,
    input logic [31:0] word_data,
    input logic        overflow,
    input logic        frm_done,
    input logic        frm_synced
);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        word_valid && !word_ready |=> word_valid && $stable(word_data) && $stable(word_right));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(frm_done && word_valid && !word_ready));

    p_load_src_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(word_valid) |-> $past(frm_done));

    p_no_word_unsynced_r1: assert property (@(posedge clk) disable iff (rst)
        !frm_synced |-> !frm_done && !word_valid);

    p_one_bit_per_period_r9: assert property (@(posedge clk) disable iff (rst)
        frm_done |=> !frm_done);
endmodule

bind audio_ser_rx audio_ser_rx_chk u_chk (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
    .word_right(word_right), .word_data(word_data), .overflow(overflow),
    .frm_done(frm_done), .frm_synced(frm_synced)
);

// File: tb/sim_audio_ser_rx.sv
module sim_audio_ser_rx;
    import audio_rx_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_clk = 1'b0;
    logic        frame_sync = 1'b0;
    logic        ser_data = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [2:0]  len_sel = 3'd4;
    logic        word_valid;
    logic [31:0] word_data;
    logic        word_right;
    logic        word_ready = 1'b1;
    logic        overflow;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [32:0] expq[$];
    string       tagq[$];

    always #2 clk = ~clk;

    audio_ser_rx u0 (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .frame_sync(frame_sync),
        .ser_data(ser_data), .fmt_sel(fmt_sel), .len_sel(len_sel),
        .word_valid(word_valid), .word_data(word_data), .word_right(word_right),
        .word_ready(word_ready), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        #1;
        if (!rst && word_valid && word_ready) begin
            if (expq.size() == 0) begin
                check(0, "R2", "unexpected word", {31'd0, word_right, word_data}, 64'd0);
            end else begin
                logic [32:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check({word_right, word_data} == e, t, "word",
                      {31'd0, word_right, word_data}, {31'd0, e});
            end
        end
    end

    function automatic logic [2:0] lcode(input int l);
        case (l)
            16: return 3'd0;
            18: return 3'd1;
            20: return 3'd2;
            24: return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    task automatic push(input logic r, input int v, input string t);
        expq.push_back({r, 32'(v)});
        tagq.push_back(t);
    endtask

    task automatic send_bit(input logic f, input logic d, input bit rdy_late = 1'b0);
        @(negedge clk); frame_sync = f; ser_data = d; bit_clk = 1'b0;
        @(negedge clk);
        @(negedge clk); bit_clk = 1'b1;
        @(negedge clk); if (rdy_late) word_ready = 1'b1;
    endtask

    task automatic do_reset(input logic [1:0] f, input int l);
        @(negedge clk);
        rst = 1'b1; fmt_sel = f; len_sel = lcode(l); bit_clk = 1'b0; word_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(word_valid == 1'b0, "R1", "valid after reset", 64'(word_valid), 64'd0);
        check(overflow == 1'b0, "R1", "overflow after reset", 64'(overflow), 64'd0);
    endtask

    task automatic preamble(input logic [1:0] f);
        for (int i = 0; i < 3; i++)
            send_bit((f == 2'd0) ? (i < 2) : 1'b0, 1'b0);
    endtask

    // one 64-slot frame; mask bit0 = expect left, bit1 = expect right
    task automatic send_frame(input logic [1:0] f, input int l, input int lv, input int rv,
                              input string t, input logic [1:0] mask = 2'b11,
                              input int rdy_bit = -1);
        logic [31:0] v;
        logic fs, d;
        if (mask[0]) push(1'b0, lv, t);
        if (mask[1]) push(1'b1, rv, t);
        for (int i = 0; i < 64; i++) begin
            int j;
            j = i % 32;
            v = (i >= 32) ? 32'(rv) : 32'(lv);
            if (f == 2'd2) d = (j >= 32 - l) ? v[31 - j] : 1'b1;
            else           d = (j < l) ? v[l - 1 - j] : 1'b1;
            if (f == 2'd0) fs = (((i + 1) % 64) >= 32);
            else           fs = (i < 32);
            send_bit(fs, d, i == rdy_bit);
        end
    endtask

    task automatic drain(input string t);
        repeat (20) @(negedge clk);
        check(expq.size() == 0, t, "words outstanding", 64'(expq.size()), 64'd0);
    endtask

    task automatic run_fmt(input logic [1:0] f, input int l, input int a, input int b,
                           input int c, input int d, input string t);
        do_reset(f, l);
        preamble(f);
        send_frame(f, l, a, b, t);
        send_frame(f, l, c, d, t);
        drain(t);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R3 I2S framing, one-bit delay, low = left
        run_fmt(2'd0, 32, 32'h12345678, -5, 32'h7fffffff, 1, "R3");
        run_fmt(2'd0, 24, 8388607, -8388608, 32'h123456, -2, "R3");
        // R4 left-justified, trailing slots ignored
        run_fmt(2'd1, 32, -19088744, 32'h0f0f0f0f, 7, -1, "R4");
        run_fmt(2'd1, 24, -3, 8388607, -8388608, 32'h00abcd, "R4");
        // R5 right-justified, R6 sign extension per length
        run_fmt(2'd2, 24, -8388608, 8388607, 32'h555555, -77, "R5");
        run_fmt(2'd2, 20, 524287, -524288, -1, 32'h12345, "R6");
        run_fmt(2'd2, 18, -1, 131071, -131072, 32'h0abcd, "R6");
        run_fmt(2'd2, 16, -32768, 32'h1234, 32767, -2, "R6");

        // R2: short half dropped, overlong half truncated at 32 slots
        do_reset(2'd1, 32);
        preamble(2'd1);
        for (int i = 0; i < 12; i++) send_bit(1'b1, 1'b1);
        push(1'b1, 32'h8badf00d, "R2");
        for (int i = 0; i < 40; i++) begin
            logic [31:0] rv;
            rv = 32'h8badf00d;
            send_bit(1'b0, (i < 32) ? rv[31 - i] : 1'b0);
        end
        send_frame(2'd1, 32, 32'h01020304, -9, "R2");
        drain("R2");

        // R8: overflow when output held through both halves
        do_reset(2'd1, 32);
        word_ready = 1'b0;
        preamble(2'd1);
        send_frame(2'd1, 32, 32'h13572468, 32'h24681357, "R8", 2'b01);
        repeat (4) @(negedge clk);
        check(overflow == 1'b1, "R8", "overflow set", 64'(overflow), 64'd1);
        check(word_valid == 1'b1 && word_data == 32'h13572468 && word_right == 1'b0,
              "R7", "held word kept", {31'd0, word_right, word_data}, 64'h13572468);
        word_ready = 1'b1;
        drain("R8");
        check(overflow == 1'b1, "R8", "overflow sticky", 64'(overflow), 64'd1);

        // R8 / R7: acceptance in the cycle the next word completes
        do_reset(2'd1, 32);
        word_ready = 1'b0;
        preamble(2'd1);
        send_frame(2'd1, 32, 32'hcafe0001, 32'hcafe0002, "R7", 2'b11, 63);
        drain("R7");
        check(overflow == 1'b0, "R8", "no overflow on same-cycle take", 64'(overflow), 64'd0);

        // R9: bits only on rising edges; idle high clock produces nothing
        do_reset(2'd1, 32);
        @(negedge clk); bit_clk = 1'b1;
        repeat (30) @(negedge clk);
        check(word_valid == 1'b0, "R9", "no word from steady clock", 64'(word_valid), 64'd0);
        bit_clk = 1'b0;
        preamble(2'd1);
        send_frame(2'd1, 32, 32'h00000001, 32'h80000000, "R9");
        drain("R9");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule